// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Sticky Timeout

This block sits between a host register bus and a downstream byte-transfer channel that drives a parallel port. It holds the port's control byte and last written data byte. It decides for every host access whether anything must reach the channel. Enhanced-mode address and data accesses go through only when the stored control byte has the exact pattern for that direction. A data access of two or four bytes is sent to the channel as a series of single bytes. Control and data-register writes that change nothing are filtered out. A change of the direction bit is announced to the channel as its own event.

The channel uses a level request with a done/error reply and never has more than one transfer open. The host holds its request until a one-cycle ready pulse. Any channel error during an enhanced-mode transfer sets a sticky timeout flag. Software sees the flag in bit 0 of a status read and clears it through a status write.

Top module: `eppGate`

## Requirements
- R1: After reset the timeout flag is 0, the control byte reads 8'hCC and the stored data byte is 8'hFF, so a data write of 8'hFF causes no channel event.
- R2: A write at offset 3 (kind 3) or offset 4 (kind 5) reaches the channel only when control bits {5,3,2,1,0} equal 5'b00100; otherwise no event occurs.
- R3: A read at offset 3 (kind 4) or offset 4 (kind 6) reaches the channel only when control bits {5,3,2,1,0} equal 5'b10100; otherwise it returns all ones at the access width (zero above) with no event.
- R4: A channel error on any kind 3 to 6 transfer sets the timeout flag, which stays set.
- R5: A write at offset 1 with bit 0 = 1 clears the timeout flag; with bit 0 = 0 it leaves the flag unchanged.
- R6: A read at offset 1 returns external status bits 7:1 with bit 0 replaced by the timeout flag, zero-extended; reads at offsets 0, 5, 6 and 7 return 8'hFF.
- R7: At offset 4 the size code 0, 1, 2 (3 behaves as 2) selects 1, 2 or 4 bytes; bytes go out least significant first, and read bytes are assembled little-endian.
- R8: After the first byte error in an enhanced-mode access the remaining bytes are skipped, and unreturned read bytes are 8'hFF.
- R9: A write at offset 0 (kind 0, the byte) occurs only if the byte differs from the stored one; a write at offset 2 (kind 1) occurs only if the value with bits 7:6 set differs from the stored control.
- R10: When a control write changes bit 5, a kind 2 event with the new direction in bit 0 precedes the kind 1 event, whose byte then has bit 5 cleared; otherwise the written byte is forwarded unchanged.
- R11: One channel transfer is open at a time, only while the host request is held; the host ready is a one-cycle pulse after the last event, and no event follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host access request, held until hostReady |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Register offset in the window |
| hostSize | input | 2 | Access size code for offset 4 |
| hostWdata | input | 32 | Write data, byte 0 in bits 7:0 |
| extStatus | input | 8 | Status byte sampled from the port |
| hostReady | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read data, valid with hostReady |
| chReq | output | 1 | Channel transfer request (level) |
| chKind | output | 3 | Channel event kind code |
| chWdata | output | 8 | Byte sent with the event |
| chRdata | input | 8 | Byte returned by the channel, valid with chDone |
| chDone | input | 1 | Channel completes the current transfer |
| chErr | input | 1 | Channel error, valid with chDone |

## Verification
A wrong stored control byte shows up at the ports on the first gated access that follows. Either an event appears that should not, or a read returns all ones where channel data was due. A stuck or lost timeout flag is visible on the next status read, in bit 0. A wrong byte index or a missed abort changes the ordered event log and the assembled read word within the same access, before hostReady.

// File: rtl/eppGatePkg.sv
package eppGatePkg;
  localparam int BUS_BYTES = 4;
  localparam int SEL_W     = $clog2(BUS_BYTES);
  localparam int BUS_W     = 8 * BUS_BYTES;

  localparam int OFF_DATA  = 0;
  localparam int OFF_STAT  = 1;
  localparam int OFF_CTRL  = 2;
  localparam int OFF_EADDR = 3;
  localparam int OFF_EDATA = 4;

  localparam logic [7:0] CTRL_RESET = 8'hCC;
  localparam logic [7:0] DATA_RESET = 8'hFF;
  localparam logic [7:0] FORCE_HI   = 8'hC0;
  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam int         DIR_BIT    = 5;

  typedef enum logic [2:0] {
    EV_DATA_WR = 3'd0,
    EV_CTRL_WR = 3'd1,
    EV_DIR     = 3'd2,
    EV_EA_WR   = 3'd3,
    EV_EA_RD   = 3'd4,
    EV_ED_WR   = 3'd5,
    EV_ED_RD   = 3'd6
  } evKind_e;

  typedef struct packed {
    logic             loadData;
    logic             loadCtrl;
    logic             clrTmo;
    logic             setTmo;
    logic             rdInit;
    logic             rdCapture;
    logic             dirFlip;
    evKind_e          kind;
    logic [SEL_W-1:0] byteSel;
  } ctlStb_t;
endpackage

// File: rtl/eppGateCtl.sv
module eppGateCtl
  import eppGatePkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [7:0]        hostByte,
  input  logic [7:0]        ctrlReg,
  input  logic [7:0]        dataReg,
  input  logic              chDone,
  input  logic              chErr,
  output ctlStb_t           stb,
  output logic              hostReady,
  output logic              chReq
);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_EADDR = ADDR_W'(OFF_EADDR);
  localparam logic [ADDR_W-1:0] A_EDATA = ADDR_W'(OFF_EDATA);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_RESP} state_e;

  state_e           st;
  evKind_e          kindR;
  logic [SEL_W-1:0] selR, lastR;
  logic             flipR;

  logic             gateW, gateR, startWork, dirDiff, kindEpp, kindRead;
  logic [7:0]       ctrlNew;
  logic [SEL_W-1:0] nLast;
  evKind_e          startKind;

  assign ctrlNew  = hostByte | FORCE_HI;
  assign dirDiff  = ctrlNew[DIR_BIT] != ctrlReg[DIR_BIT];
  assign gateW    = (ctrlReg & GATE_MASK) == GATE_WR;
  assign gateR    = (ctrlReg & GATE_MASK) == GATE_RD;
  assign kindEpp  = kindR inside {EV_EA_WR, EV_EA_RD, EV_ED_WR, EV_ED_RD};
  assign kindRead = kindR inside {EV_EA_RD, EV_ED_RD};

  always_comb begin
    nLast = '0;
    if (hostAddr == A_EDATA) begin
      case (hostSize)
        2'd0:    nLast = SEL_W'(0);
        2'd1:    nLast = SEL_W'(1);
        default: nLast = SEL_W'(BUS_BYTES - 1);
      endcase
    end
  end

  always_comb begin
    startWork = 1'b0;
    startKind = EV_DATA_WR;
    if (hostAddr == A_DATA) begin
      startWork = hostWr && (hostByte != dataReg);
    end else if (hostAddr == A_CTRL) begin
      startWork = hostWr && (ctrlNew != ctrlReg);
      startKind = dirDiff ? EV_DIR : EV_CTRL_WR;
    end else if (hostAddr == A_EADDR) begin
      startWork = hostWr ? gateW : gateR;
      startKind = hostWr ? EV_EA_WR : EV_EA_RD;
    end else if (hostAddr == A_EDATA) begin
      startWork = hostWr ? gateW : gateR;
      startKind = hostWr ? EV_ED_WR : EV_ED_RD;
    end
  end

  logic accept;
  assign accept = (st == S_IDLE) && hostReq;

  always_comb begin
    stb           = '0;
    stb.kind      = kindR;
    stb.byteSel   = selR;
    stb.dirFlip   = flipR;
    stb.loadData  = accept && hostWr && (hostAddr == A_DATA);
    stb.loadCtrl  = accept && hostWr && (hostAddr == A_CTRL);
    stb.clrTmo    = accept && hostWr && (hostAddr == A_STAT) && hostByte[0];
    stb.rdInit    = accept && !hostWr;
    stb.setTmo    = (st == S_XFER) && chDone && chErr && kindEpp;
    stb.rdCapture = (st == S_XFER) && chDone && !chErr && kindRead;
  end

  assign chReq     = (st == S_XFER);
  assign hostReady = (st == S_RESP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= S_IDLE;
      kindR <= EV_DATA_WR;
      selR  <= '0;
      lastR <= '0;
      flipR <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (hostReq) begin
          kindR <= startKind;
          selR  <= '0;
          lastR <= nLast;
          flipR <= (hostAddr == A_CTRL) && dirDiff;
          st    <= startWork ? S_XFER : S_RESP;
        end
        S_XFER: if (chDone) begin
          if (kindR == EV_DIR)
            kindR <= EV_CTRL_WR;
          else if ((chErr && kindEpp) || selR == lastR)
            st <= S_RESP;
          else
            selR <= selR + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eppGateDp.sv
module eppGateDp
  import eppGatePkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [BUS_W-1:0]  hostWdata,
  input  logic [7:0]        extStatus,
  input  logic [7:0]        chRdata,
  output logic [7:0]        ctrlReg,
  output logic [7:0]        dataReg,
  output logic [BUS_W-1:0]  hostRdata,
  output logic [7:0]        chWdata
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_EDATA = ADDR_W'(OFF_EDATA);

  logic             tmoFlag;
  logic [BUS_W-1:0] rdReg, preset, widthMask;
  logic [7:0]       selByte;

  always_comb begin
    widthMask = BUS_W'(8'hFF);
    if (hostAddr == A_EDATA) begin
      case (hostSize)
        2'd0:    widthMask = BUS_W'(8'hFF);
        2'd1:    widthMask = BUS_W'(16'hFFFF);
        default: widthMask = '1;
      endcase
    end
  end

  always_comb begin
    if (hostAddr == A_STAT)      preset = BUS_W'({extStatus[7:1], tmoFlag});
    else if (hostAddr == A_CTRL) preset = BUS_W'(ctrlReg);
    else                         preset = widthMask;
  end

  assign selByte = hostWdata[8*stb.byteSel +: 8];

  always_comb begin
    case (stb.kind)
      EV_DATA_WR: chWdata = hostWdata[7:0];
      EV_CTRL_WR: chWdata = stb.dirFlip ? (hostWdata[7:0] & ~(8'h1 << DIR_BIT))
                                        : hostWdata[7:0];
      EV_DIR:     chWdata = {7'd0, hostWdata[DIR_BIT]};
      EV_EA_WR:   chWdata = hostWdata[7:0];
      EV_ED_WR:   chWdata = selByte;
      default:    chWdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      dataReg <= DATA_RESET;
      tmoFlag <= 1'b0;
      rdReg   <= '1;
    end else begin
      if (stb.loadCtrl) ctrlReg <= hostWdata[7:0] | FORCE_HI;
      if (stb.loadData) dataReg <= hostWdata[7:0];
      if (stb.setTmo)      tmoFlag <= 1'b1;
      else if (stb.clrTmo) tmoFlag <= 1'b0;
      if (stb.rdInit)         rdReg <= preset;
      else if (stb.rdCapture) rdReg[8*stb.byteSel +: 8] <= chRdata;
    end
  end

  assign hostRdata = rdReg;
endmodule

// File: rtl/eppGate.sv
module eppGate
  import eppGatePkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  input  logic [7:0]        extStatus,
  output logic              hostReady,
  output logic [31:0]       hostRdata,
  output logic              chReq,
  output logic [2:0]        chKind,
  output logic [7:0]        chWdata,
  input  logic [7:0]        chRdata,
  input  logic              chDone,
  input  logic              chErr
);
  ctlStb_t    stb;
  logic [7:0] ctrlReg, dataReg;

  eppGateCtl #(.ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostByte(hostWdata[7:0]),
    .ctrlReg(ctrlReg), .dataReg(dataReg), .chDone(chDone), .chErr(chErr),
    .stb(stb), .hostReady(hostReady), .chReq(chReq)
  );

  eppGateDp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr),
    .hostSize(hostSize), .hostWdata(hostWdata), .extStatus(extStatus),
    .chRdata(chRdata), .ctrlReg(ctrlReg), .dataReg(dataReg),
    .hostRdata(hostRdata), .chWdata(chWdata)
  );

  assign chKind = stb.kind;
endmodule

// File: rtl/eppGateChk.sv
module eppGateChk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReq,
  input logic              hostWr,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [1:0]        hostSize,
  input logic              hostReady,
  input logic [31:0]       hostRdata,
  input logic              chReq,
  input logic [2:0]        chKind,
  input logic [7:0]        chWdata,
  input logic              chDone
);
  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  assert_no_req_at_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> !chReq);

  assert_req_needs_host_R11: assert property (@(posedge clk) disable iff (!rstN)
    chReq |-> hostReq);

  assert_xfer_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chReq && $past(chReq) && !$past(chDone)) |-> ($stable(chKind) && $stable(chWdata)));

  assert_narrow_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && !hostWr && hostAddr == ADDR_W'(4) && hostSize == 2'd0)
      |-> (hostRdata[31:8] == 24'd0));

  assert_status_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && !hostWr && hostAddr == ADDR_W'(1)) |-> (hostRdata[31:8] == 24'd0));
endmodule

bind eppGate eppGateChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
  .hostAddr(hostAddr), .hostSize(hostSize), .hostReady(hostReady),
  .hostRdata(hostRdata), .chReq(chReq), .chKind(chKind),
  .chWdata(chWdata), .chDone(chDone)
);

// File: tb/test_eppGate.sv
`timescale 1ns/1ps
module test_eppGate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWr = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [7:0]  extStatus = '0;
  logic        hostReady;
  logic [31:0] hostRdata;
  logic        chReq;
  logic [2:0]  chKind;
  logic [7:0]  chWdata;
  logic [7:0]  chRdata;
  logic        chDone, chErr;

  always #5 clk = ~clk;

  eppGate i_eppGate (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .extStatus(extStatus), .hostReady(hostReady), .hostRdata(hostRdata),
    .chReq(chReq), .chKind(chKind), .chWdata(chWdata), .chRdata(chRdata),
    .chDone(chDone), .chErr(chErr)
  );

  int nChecks = 0, nFails = 0;
  int logN, base, errAt, lat, cnt, cycles;
  logic [2:0] logKind [0:2047];
  logic [7:0] logData [0:2047];
  logic [7:0] rdBytes [0:3];

  // channel model: level request, done after lat idle cycles
  always @(posedge clk) begin
    if (!rstN) begin
      chDone <= 1'b0; chErr <= 1'b0; cnt <= 0; logN <= 0; chRdata <= 8'h00;
    end else if (chDone) begin
      chDone <= 1'b0; chErr <= 1'b0; cnt <= 0;
    end else if (chReq) begin
      if (cnt >= lat) begin
        chDone  <= 1'b1;
        chErr   <= (logN == errAt);
        chRdata <= rdBytes[(logN - base) & 3];
        logKind[logN % 2048] <= chKind;
        logData[logN % 2048] <= chWdata;
        logN <= logN + 1;
      end else cnt <= cnt + 1;
    end
  end

  // bench reference state
  logic [7:0] mCtrl = 8'hCC, mData = 8'hFF;
  logic       mTmo = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL R11 watchdog: actual %0d expected <150000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic access(input string tag, input bit wr, input logic [2:0] addr,
                        input logic [1:0] size, input logic [31:0] wd,
                        input logic [7:0] ext, input int errK);
    logic [2:0]  ek [0:7];
    logic [7:0]  ed [0:7];
    int          en = 0;
    int          nb;
    logic [31:0] expRd = 32'hFF, rd;
    logic [7:0]  nv;
    logic        gW, gR;
    nb = (addr == 3'd4) ? ((size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4) : 1;
    gW = (mCtrl & 8'h2F) == 8'h04;
    gR = (mCtrl & 8'h2F) == 8'h24;
    if (wr) begin
      case (addr)
        3'd0: if (wd[7:0] != mData) begin ek[en] = 3'd0; ed[en] = wd[7:0]; en++; mData = wd[7:0]; end
        3'd1: if (wd[0]) mTmo = 1'b0;
        3'd2: begin
          nv = wd[7:0] | 8'hC0;
          if (nv != mCtrl) begin
            if (nv[5] != mCtrl[5]) begin
              ek[en] = 3'd2; ed[en] = {7'd0, nv[5]}; en++;
              ek[en] = 3'd1; ed[en] = wd[7:0] & 8'hDF; en++;
            end else begin
              ek[en] = 3'd1; ed[en] = wd[7:0]; en++;
            end
            mCtrl = nv;
          end
        end
        3'd3, 3'd4: if (gW) begin
          for (int i = 0; i < nb; i++) begin
            ek[en] = (addr == 3'd3) ? 3'd3 : 3'd5; ed[en] = wd[8*i +: 8]; en++;
            if (i == errK) begin mTmo = 1'b1; break; end
          end
        end
        default: ;
      endcase
    end else begin
      case (addr)
        3'd1: expRd = {24'd0, ext[7:1], mTmo};
        3'd2: expRd = {24'd0, mCtrl};
        3'd3, 3'd4: begin
          expRd = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFFFFFF;
          if (gR) begin
            for (int i = 0; i < nb; i++) begin
              ek[en] = (addr == 3'd3) ? 3'd4 : 3'd6; ed[en] = 8'h00; en++;
              if (i == errK) begin mTmo = 1'b1; break; end
              expRd[8*i +: 8] = rdBytes[i];
            end
          end
        end
        default: expRd = 32'hFF;
      endcase
    end
    // drive
    @(negedge clk);
    base = logN; errAt = logN + errK;
    hostWr = wr; hostAddr = addr; hostSize = size; hostWdata = wd;
    extStatus = ext; hostReq = 1'b1;
    do @(negedge clk); while (!hostReady);
    rd = hostRdata;
    hostReq = 1'b0;
    repeat (2) @(negedge clk);
    chk((logN - base) == en, tag, "event count (R11 none after ready)", logN - base, en);
    for (int i = 0; i < en && i < (logN - base); i++) begin
      chk(logKind[(base + i) % 2048] == ek[i], tag, "event kind",
          {29'd0, logKind[(base + i) % 2048]}, {29'd0, ek[i]});
      chk(logData[(base + i) % 2048] == ed[i], tag, "event byte",
          {24'd0, logData[(base + i) % 2048]}, {24'd0, ed[i]});
    end
    if (!wr) chk(rd == expRd, tag, "read data", rd, expRd);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    cycles = 0; lat = 1; errAt = -1; base = 0;
    for (int i = 0; i < 4; i++) rdBytes[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    access("R1 control reset", 0, 3'd2, 2'd0, 0, 8'h00, 9);
    access("R1 status reset", 0, 3'd1, 2'd0, 0, 8'h5B, 9);
    access("R1 data reset FF (R9)", 1, 3'd0, 2'd0, 32'hFF, 8'h00, 9);
    // R2 / R3 blocked in reset control pattern
    access("R2 blocked data write", 1, 3'd4, 2'd2, 32'hDEADBEEF, 8'h00, 9);
    access("R2 blocked addr write", 1, 3'd3, 2'd0, 32'h12, 8'h00, 9);
    access("R3 blocked read 4B", 0, 3'd4, 2'd2, 0, 8'h00, 9);
    access("R3 blocked read 2B", 0, 3'd4, 2'd1, 0, 8'h00, 9);
    access("R9 control write", 1, 3'd2, 2'd0, 32'h04, 8'h00, 9);
    access("R2 addr write", 1, 3'd3, 2'd0, 32'h37, 8'h00, 9);
    access("R7 data write 4B order", 1, 3'd4, 2'd2, 32'h11223344, 8'h00, 9);
    access("R7 data write size3", 1, 3'd4, 2'd3, 32'hA1B2C3D4, 8'h00, 9);
    access("R8 write abort (R4)", 1, 3'd4, 2'd2, 32'h55667788, 8'h00, 1);
    access("R4 status shows flag", 0, 3'd1, 2'd0, 0, 8'hFF, 9);
    access("R5 write bit0=0 keeps", 1, 3'd1, 2'd0, 32'hFE, 8'h00, 9);
    access("R6 status merge", 0, 3'd1, 2'd0, 0, 8'h00, 9);
    access("R5 write bit0=1 clears", 1, 3'd1, 2'd0, 32'h01, 8'h00, 9);
    access("R5 status after clear", 0, 3'd1, 2'd0, 0, 8'hA7, 9);
    access("R10 direction change", 1, 3'd2, 2'd0, 32'h24, 8'h00, 9);
    rdBytes[0] = 8'h9A; rdBytes[1] = 8'hBC; rdBytes[2] = 8'hDE; rdBytes[3] = 8'hF0;
    access("R7 read 4B little-endian", 0, 3'd4, 2'd2, 0, 8'h00, 9);
    access("R7 read 2B", 0, 3'd4, 2'd1, 0, 8'h00, 9);
    access("R8 read abort fills FF", 0, 3'd4, 2'd2, 0, 8'h00, 2);
    access("R3 addr read", 0, 3'd3, 2'd0, 0, 8'h00, 9);
    access("R9 control dedup bits 7:6", 1, 3'd2, 2'd0, 32'hE4, 8'h00, 9);
    access("R9 data write", 1, 3'd0, 2'd0, 32'h5A, 8'h00, 9);
    access("R9 data dedup", 1, 3'd0, 2'd0, 32'h5A, 8'h00, 9);
    access("R6 other offset", 0, 3'd5, 2'd0, 0, 8'h00, 9);
    access("R10 direction back", 1, 3'd2, 2'd0, 32'h04, 8'h00, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  a;
      logic [31:0] w;
      int          pick, ek2;
      pick = $urandom % 10;
      a = (pick < 3) ? 3'd4 : (pick < 4) ? 3'd3 : (pick < 6) ? 3'd2 :
          (pick < 8) ? 3'd1 : (pick < 9) ? 3'd0 : 3'd7;
      w = $urandom;
      if (a == 3'd2) begin
        pick = $urandom % 3;
        if (pick == 0) w[7:0] = 8'h04; else if (pick == 1) w[7:0] = 8'h24;
      end
      if (a == 3'd0) w[7:0] = {6'd0, w[1:0]};
      ek2 = (($urandom % 4) == 0) ? int'($urandom % 4) : 9;
      lat = $urandom % 4;
      for (int i = 0; i < 4; i++) rdBytes[i] = 8'($urandom);
      access("R7 R4 random", 1'($urandom), a, 2'($urandom), w, 8'($urandom), ek2);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule